// File: doc/BRIEF.md
# Blanking-Aware 4:2:2 Byte Formatter

This block sits at the end of a video decode pipeline. It turns processed 4:2:2 luma and chroma into a single 8-bit byte stream, one byte per clock, together with a blanking flag and a data-valid flag. A pixel counter restarts from a sync strobe. That counter, and a line number latched at the same strobe, are compared against programmable window registers to decide which bytes fall in the blanked region. Blanked bytes carry fixed black and zero-chroma levels, unless ancillary data is flagged as valid on the input.

A two-bit select can replace the live picture with built-in content. The choices are eight 75% color bars spread evenly across the active span, a flat blue field, or a flat black field. All output codes are held clear of the two reserved byte values 0x00 and 0xFF.

The horizontal window is defined in pixel pairs, so every active run starts on a chroma-blue byte. Because the counter origin is the sync edge, the window that begins blanking normally sits near the end of the previous line and wraps through zero.

Top module: `pix_out_formatter`

## Requirements
- R1: While reset is active, out_blank is 1, out_dvalid is 0 and out_byte is 0x10.
- R2: Bytes follow the slot order Cb, Y, Cr, Y (slot = byte count mod 4). The clock after a sync_stb cycle carries pixel 0, slot Cb, even when the strobe arrives mid-group. Chroma slots take in_c and luma slots take in_y.
- R3: Horizontal blanking is tested only on Cb slots, against the pair index (pixel count / 2). It is set when the pair equals hblank_on_pair and cleared when the pair equals hblank_off_pair; when both match, set wins. The state holds across sync, so a window can wrap through pair 0.
- R4: On each sync_stb, line_num is checked against the window of the field given by field_id (f0 or f1). The window is inclusive from first to last, and wraps when first > last. The result blanks the whole following line.
- R5: A blanked byte is 0x10 on luma slots and 0x80 on chroma slots. The only exception is when pat_sel = 0 and vbi_valid = 1: then the input byte passes.
- R6: Every byte is clamped to the range 0x01 to 0xFE.
- R7: pat_sel picks the content of active bytes: 0 live input, 1 color bars, 2 blue field (Y 23, Cb D4, Cr 72 in hex), 3 black field (Y 10, Cb 80, Cr 80).
- R8: The bar colors (Y/Cb/Cr in hex) for index 0 to 7 are: white B4/80/80, yellow A2/2C/8E, cyan 83/9C/2C, green 70/48/3A, magenta 54/B8/C6, red 41/64/D4, blue 23/D4/72, black 10/80/80. Let k be the pair count since active video began and D = (hblank_on_pair − hblank_off_pair) mod 2^(HW−1). The index is min(k / max(D/8, 1), 7), where D/8 is floor division.
- R9: out_dvalid is 1 on every clock after the first edge following reset release.
- R10: out_byte and out_blank reflect the inputs and state of the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_stb | input | 1 | Sync leading-edge strobe; restarts the pixel count |
| line_num | input | LW | Number of the line that follows the strobe |
| field_id | input | 1 | Field of the line that follows the strobe |
| vbi_valid | input | 1 | Ancillary data present on the inputs |
| in_y | input | 8 | Luma sample for the current pixel |
| in_c | input | 8 | Chroma sample (Cb or Cr) for the current pixel |
| hblank_on_pair | input | HW-1 | Pair index at which blanking begins |
| hblank_off_pair | input | HW-1 | Pair index at which blanking ends |
| vblank_first_f0 | input | LW | First blanked line, field 0 |
| vblank_last_f0 | input | LW | Last blanked line, field 0 |
| vblank_first_f1 | input | LW | First blanked line, field 1 |
| vblank_last_f1 | input | LW | Last blanked line, field 1 |
| pat_sel | input | 2 | Content select |
| out_byte | output | 8 | Multiplexed output byte |
| out_blank | output | 1 | Blanking flag |
| out_dvalid | output | 1 | Byte valid |

## Verification
The hardest case to reach is a line on which the horizontal window never reopens because start and end name the same pair. A close second is a bar index that must saturate because the active span is not a multiple of eight bar widths. The stimulus reaches both by rewriting the window registers between sync strobes while the stream is running, so the blank state carried over from the previous line decides the outcome. A truncated line, whose strobe lands on a luma slot, shows that the slot order realigns. Field-1 windows that wrap past the top line number exercise the inclusive wrap rule.

// File: rtl/pof_pkg.sv
package pof_pkg;

  typedef enum logic [1:0] {
    PAT_LIVE  = 2'd0,
    PAT_BARS  = 2'd1,
    PAT_BLUE  = 2'd2,
    PAT_BLACK = 2'd3
  } pat_e;

  // slot[1] = chroma kind (0 Cb, 1 Cr), slot[0] = luma byte
  typedef enum logic [1:0] {
    SLOT_CB = 2'd0,
    SLOT_Y0 = 2'd1,
    SLOT_CR = 2'd2,
    SLOT_Y1 = 2'd3
  } slot_e;

  typedef struct packed {
    logic [7:0] y;
    logic [7:0] cb;
    logic [7:0] cr;
  } ycc_t;

  localparam logic [7:0] LUMA_BLANK  = 8'h10;
  localparam logic [7:0] CHROMA_ZERO = 8'h80;
  localparam logic [7:0] CODE_MIN    = 8'h01;
  localparam logic [7:0] CODE_MAX    = 8'hFE;
  localparam ycc_t       BLUE_FIELD  = '{y: 8'h23, cb: 8'hD4, cr: 8'h72};
  localparam ycc_t       BLACK_FIELD = '{y: 8'h10, cb: 8'h80, cr: 8'h80};

  function automatic ycc_t bar_color(input logic [2:0] idx);
    ycc_t c;
    case (idx)
      3'd0:    c = '{y: 8'hB4, cb: 8'h80, cr: 8'h80};
      3'd1:    c = '{y: 8'hA2, cb: 8'h2C, cr: 8'h8E};
      3'd2:    c = '{y: 8'h83, cb: 8'h9C, cr: 8'h2C};
      3'd3:    c = '{y: 8'h70, cb: 8'h48, cr: 8'h3A};
      3'd4:    c = '{y: 8'h54, cb: 8'hB8, cr: 8'hC6};
      3'd5:    c = '{y: 8'h41, cb: 8'h64, cr: 8'hD4};
      3'd6:    c = '{y: 8'h23, cb: 8'hD4, cr: 8'h72};
      default: c = '{y: 8'h10, cb: 8'h80, cr: 8'h80};
    endcase
    return c;
  endfunction

  function automatic logic [7:0] slot_byte(input ycc_t c, input slot_e s);
    logic [7:0] b;
    case (s)
      SLOT_CB: b = c.cb;
      SLOT_CR: b = c.cr;
      default: b = c.y;
    endcase
    return b;
  endfunction

  function automatic logic [7:0] clamp_code(input logic [7:0] v);
    logic [7:0] r;
    if (v < CODE_MIN)      r = CODE_MIN;
    else if (v > CODE_MAX) r = CODE_MAX;
    else                   r = v;
    return r;
  endfunction

endpackage

// File: rtl/pof_hcount.sv
module pof_hcount
  import pof_pkg::*;
#(
  parameter int HW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_stb,
  input  logic [HW-2:0] on_pair,
  input  logic [HW-2:0] off_pair,
  output slot_e         slot,
  output logic          hblank,
  output logic [2:0]    bar_idx
);

  localparam int PW        = HW - 1;
  localparam int BAR_LOG2  = 3;
  localparam logic [2:0] BAR_TOP = 3'd7;

  logic [HW-1:0] pix_q, pix_d;
  logic          lum_q, lum_d;
  logic          hb_q, hb_d;
  logic [2:0]    idx_q, idx_d;
  logic [PW-1:0] sub_q, sub_d;
  logic [PW-1:0] pair, span, bar_w, bar_last;
  logic          grp, hit_on, hit_off, act_begin, bar_done;

  always_comb begin
    pair    = pix_q[HW-1:1];
    grp     = ~pix_q[0] & ~lum_q;
    hit_on  = grp && (pair == on_pair);
    hit_off = grp && (pair == off_pair);

    if (hit_on)       hb_d = 1'b1;
    else if (hit_off) hb_d = 1'b0;
    else              hb_d = hb_q;
    act_begin = hb_q & ~hb_d;

    span     = on_pair - off_pair;
    bar_w    = ((span >> BAR_LOG2) == '0) ? PW'(1) : (span >> BAR_LOG2);
    bar_last = bar_w - PW'(1);
    bar_done = (sub_q == bar_last);

    idx_d = idx_q;
    sub_d = sub_q;
    if (act_begin) begin
      idx_d = 3'd0;
      sub_d = '0;
    end else if (grp) begin
      if (bar_done) begin
        sub_d = '0;
        if (idx_q != BAR_TOP) idx_d = idx_q + 3'd1;
      end else begin
        sub_d = sub_q + PW'(1);
      end
    end

    if (sync_stb) begin
      pix_d = '0;
      lum_d = 1'b0;
    end else begin
      pix_d = pix_q + HW'(lum_q);
      lum_d = ~lum_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q <= '0;
      lum_q <= 1'b0;
    end else begin
      pix_q <= pix_d;
      lum_q <= lum_d;
    end
  end

  // window and bar state only move on Cb slots
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hb_q  <= 1'b1;
      idx_q <= 3'd0;
      sub_q <= '0;
    end else if (grp) begin
      hb_q  <= hb_d;
      idx_q <= idx_d;
      sub_q <= sub_d;
    end
  end

  assign slot    = slot_e'({pix_q[0], lum_q});
  assign hblank  = hb_d;
  assign bar_idx = idx_d;

  p_sync_origin_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sync_stb |=> (pix_q == '0 && !lum_q));

  p_hb_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!grp) |=> $stable(hb_q));

  p_bar_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q == BAR_TOP && !act_begin) |=> (idx_q == BAR_TOP));

endmodule

// File: rtl/pof_vgate.sv
module pof_vgate #(
  parameter int LW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_stb,
  input  logic [LW-1:0] line_num,
  input  logic          field_id,
  input  logic [LW-1:0] first_f0,
  input  logic [LW-1:0] last_f0,
  input  logic [LW-1:0] first_f1,
  input  logic [LW-1:0] last_f1,
  output logic          vblank
);

  localparam int NFIELD = 2;

  logic [LW-1:0] wfirst [NFIELD];
  logic [LW-1:0] wlast  [NFIELD];
  logic [NFIELD-1:0] inwin;
  logic vb_q, vb_d;

  assign wfirst[0] = first_f0;
  assign wlast[0]  = last_f0;
  assign wfirst[1] = first_f1;
  assign wlast[1]  = last_f1;

  for (genvar f = 0; f < NFIELD; f++) begin : g_win
    assign inwin[f] = (wfirst[f] <= wlast[f])
                    ? ((line_num >= wfirst[f]) && (line_num <= wlast[f]))
                    : ((line_num >= wfirst[f]) || (line_num <= wlast[f]));
  end

  always_comb begin
    vb_d = sync_stb ? inwin[field_id] : vb_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vb_q <= 1'b1;
    else        vb_q <= vb_d;
  end

  assign vblank = vb_q;

  p_vb_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_stb) |=> $stable(vb_q));

endmodule

// File: rtl/pof_bytemux.sv
module pof_bytemux
  import pof_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  slot_e      slot,
  input  logic       blank,
  input  logic [2:0] bar_idx,
  input  logic [1:0] pat_sel,
  input  logic       vbi_valid,
  input  logic [7:0] in_y,
  input  logic [7:0] in_c,
  output logic [7:0] out_byte,
  output logic       out_blank,
  output logic       out_dvalid
);

  pat_e       pat;
  ycc_t       col;
  logic       luma, pass_vbi, forced;
  logic [7:0] raw, byte_d;
  logic [7:0] byte_q;
  logic       blank_q, dv_q;

  always_comb begin
    pat      = pat_e'(pat_sel);
    luma     = (slot == SLOT_Y0) || (slot == SLOT_Y1);
    pass_vbi = (pat == PAT_LIVE) && vbi_valid;
    forced   = blank && !pass_vbi;
    case (pat)
      PAT_BARS: col = bar_color(bar_idx);
      PAT_BLUE: col = BLUE_FIELD;
      default:  col = BLACK_FIELD;
    endcase
    if (forced)               raw = luma ? LUMA_BLANK : CHROMA_ZERO;
    else if (pat == PAT_LIVE) raw = luma ? in_y : in_c;
    else                      raw = slot_byte(col, slot);
    byte_d = clamp_code(raw);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q  <= LUMA_BLANK;
      blank_q <= 1'b1;
      dv_q    <= 1'b0;
    end else begin
      byte_q  <= byte_d;
      blank_q <= blank;
      dv_q    <= 1'b1;
    end
  end

  assign out_byte   = byte_q;
  assign out_blank  = blank_q;
  assign out_dvalid = dv_q;

  p_code_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_q >= CODE_MIN) && (byte_q <= CODE_MAX));

  p_blank_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (blank && !(pat_sel == 2'd0 && vbi_valid)) |=>
      (byte_q == LUMA_BLANK || byte_q == CHROMA_ZERO));

  p_dvalid_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dv_q |=> dv_q);

endmodule

// File: rtl/pix_out_formatter.sv
module pix_out_formatter
  import pof_pkg::*;
#(
  parameter int HW = 11,
  parameter int LW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_stb,
  input  logic [LW-1:0] line_num,
  input  logic          field_id,
  input  logic          vbi_valid,
  input  logic [7:0]    in_y,
  input  logic [7:0]    in_c,
  input  logic [HW-2:0] hblank_on_pair,
  input  logic [HW-2:0] hblank_off_pair,
  input  logic [LW-1:0] vblank_first_f0,
  input  logic [LW-1:0] vblank_last_f0,
  input  logic [LW-1:0] vblank_first_f1,
  input  logic [LW-1:0] vblank_last_f1,
  input  logic [1:0]    pat_sel,
  output logic [7:0]    out_byte,
  output logic          out_blank,
  output logic          out_dvalid
);

  slot_e      slot;
  logic       hblank, vblank, blank;
  logic [2:0] bar_idx;

  pof_hcount #(.HW(HW)) u_hcount (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_stb (sync_stb),
    .on_pair  (hblank_on_pair),
    .off_pair (hblank_off_pair),
    .slot     (slot),
    .hblank   (hblank),
    .bar_idx  (bar_idx)
  );

  pof_vgate #(.LW(LW)) u_vgate (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_stb (sync_stb),
    .line_num (line_num),
    .field_id (field_id),
    .first_f0 (vblank_first_f0),
    .last_f0  (vblank_last_f0),
    .first_f1 (vblank_first_f1),
    .last_f1  (vblank_last_f1),
    .vblank   (vblank)
  );

  assign blank = hblank | vblank;

  pof_bytemux u_bytemux (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot       (slot),
    .blank      (blank),
    .bar_idx    (bar_idx),
    .pat_sel    (pat_sel),
    .vbi_valid  (vbi_valid),
    .in_y       (in_y),
    .in_c       (in_c),
    .out_byte   (out_byte),
    .out_blank  (out_blank),
    .out_dvalid (out_dvalid)
  );

  p_blank_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hblank || vblank) |=> out_blank);

  p_active_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!hblank && !vblank) |=> !out_blank);

endmodule

// File: tb/pix_out_formatter_bench.sv
module pix_out_formatter_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HW = 11;
  localparam int LW = 10;
  localparam int PMASK = (1 << (HW - 1)) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sync_stb = 1'b0;
  logic [LW-1:0] line_num = '0;
  logic          field_id = 1'b0;
  logic          vbi_valid = 1'b0;
  logic [7:0]    in_y = 8'h00;
  logic [7:0]    in_c = 8'h00;
  logic [HW-2:0] on_pair = 10'd27;
  logic [HW-2:0] off_pair = 10'd3;
  logic [LW-1:0] f0_first = 10'd0, f0_last = 10'd3;
  logic [LW-1:0] f1_first = 10'd10, f1_last = 10'd1;
  logic [1:0]    pat = 2'd0;
  logic [7:0]    out_byte;
  logic          out_blank, out_dvalid;

  always #(CLK_PERIOD/2) clk = ~clk;

  pix_out_formatter #(.HW(HW), .LW(LW)) u_pix_out_formatter (
    .clk(clk), .rst_n(rst_n), .sync_stb(sync_stb), .line_num(line_num),
    .field_id(field_id), .vbi_valid(vbi_valid), .in_y(in_y), .in_c(in_c),
    .hblank_on_pair(on_pair), .hblank_off_pair(off_pair),
    .vblank_first_f0(f0_first), .vblank_last_f0(f0_last),
    .vblank_first_f1(f1_first), .vblank_last_f1(f1_last),
    .pat_sel(pat), .out_byte(out_byte), .out_blank(out_blank),
    .out_dvalid(out_dvalid)
  );

  typedef struct {
    logic [7:0] b;
    logic       bl;
    string      tag;
  } exp_t;
  exp_t q[$];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  int n = 0;
  bit hb_m = 1, vb_m = 1;
  int act0 = 0;

  function automatic logic [23:0] bar_tab(input int i);
    case (i)
      0: return 24'hB48080;
      1: return 24'hA22C8E;
      2: return 24'h839C2C;
      3: return 24'h70483A;
      4: return 24'h54B8C6;
      5: return 24'h4164D4;
      6: return 24'h23D472;
      default: return 24'h108080;
    endcase
  endfunction

  function automatic bit win(input int line, input int first, input int last);
    if (first <= last) return (line >= first) && (line <= last);
    return (line >= first) || (line <= last);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // driver: one byte per call, expected result queued for the next edge (R10)
  task automatic step(input bit sync, input int line, input bit fld, input bit vbi,
                      input logic [7:0] y, input logic [7:0] c);
    int pair, slot, d, bw, k, idx, sel;
    bit luma, blank, hbn;
    logic [7:0] raw, e;
    logic [23:0] col;
    string tag;
    exp_t it;
    sync_stb = sync; line_num = LW'(line); field_id = fld;
    vbi_valid = vbi; in_y = y; in_c = c;
    sel  = int'(pat);
    pair = (n >> 2) & PMASK;
    slot = n % 4;
    luma = slot[0];
    if (slot == 0) begin
      if (pair == int'(on_pair))       hbn = 1;
      else if (pair == int'(off_pair)) hbn = 0;
      else                             hbn = hb_m;
      if (hb_m && !hbn) act0 = pair;
      hb_m = hbn;
    end
    blank = hb_m | vb_m;
    d  = (int'(on_pair) - int'(off_pair)) & PMASK;
    bw = ((d >> 3) == 0) ? 1 : (d >> 3);
    k  = (pair - act0) & PMASK;
    idx = k / bw;
    if (idx > 7) idx = 7;
    if (blank && !(sel == 0 && vbi)) begin
      e = luma ? 8'h10 : 8'h80; tag = "R5 blank level";
    end else if (sel == 0) begin
      raw = luma ? y : c;
      e = (raw == 8'h00) ? 8'h01 : (raw == 8'hFF) ? 8'hFE : raw;
      tag = blank ? "R5 ancillary pass" : (raw != e) ? "R6 clamp" : "R2 slot order";
    end else begin
      if (sel == 1)      col = bar_tab(idx);
      else if (sel == 2) col = 24'h23D472;
      else               col = 24'h108080;
      e = (slot == 0) ? col[15:8] : (slot == 2) ? col[7:0] : col[23:16];
      tag = (sel == 1) ? "R8 bar code" : "R7 field code";
    end
    it.b = e; it.bl = blank; it.tag = tag;
    q.push_back(it);
    if (sync) begin
      n = 0;
      vb_m = fld ? win(line, f1_first, f1_last) : win(line, f0_first, f0_last);
    end else begin
      n++;
    end
    @(negedge clk);
  endtask

  task automatic run_line(input int nbytes, input int nxt, input bit nfld,
                          input bit vbi, input int dmode);
    for (int i = 0; i < nbytes; i++) begin
      logic [7:0] y, c;
      if (dmode == 1) begin
        y = 8'hFF; c = 8'h00;
      end else begin
        y = 8'((i * 7) & 255); c = 8'((i * 13 + 200) & 255);
      end
      step(i == nbytes - 1, nxt, nfld, vbi, y, c);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // monitor: compare one cycle after each push, away from the edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(out_byte === e.b, e.tag, out_byte, e.b);
        check(out_blank === e.bl, "R3 R4 blank flag", out_blank, e.bl);
        check(out_dvalid === 1'b1, "R9 dvalid", out_dvalid, 1);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(out_blank === 1'b1, "R1 reset blank", out_blank, 1);
    check(out_dvalid === 1'b0, "R1 reset dvalid", out_dvalid, 0);
    check(out_byte === 8'h10, "R1 reset byte", out_byte, 8'h10);
    @(negedge clk);
    rst_n = 1'b1;
    run_line(40, 5, 0, 0, 0);          // partial, blanked by reset state
    run_line(120, 6, 0, 0, 0);         // R2 live line 5, window wraps (R3)
    run_line(120, 7, 0, 0, 1);         // R6 extremes on line 6
    pat = 2'd1;
    run_line(120, 8, 0, 0, 0);         // R8 bars
    run_line(120, 2, 0, 1, 0);         // R8 bars, vbi has no effect when active
    pat = 2'd0;
    run_line(120, 3, 0, 1, 0);         // R5 line 2 blanked, ancillary passes
    run_line(120, 2, 0, 0, 0);         // R5 line 3 blanked levels
    pat = 2'd1;
    run_line(120, 9, 0, 1, 0);         // R5 pattern mode forces levels
    pat = 2'd2;
    run_line(120, 10, 0, 0, 0);        // R7 blue
    pat = 2'd3;
    run_line(120, 0, 1, 0, 0);         // R7 black
    pat = 2'd0;
    run_line(120, 5, 1, 0, 0);         // R4 f1 line 0 (wrap window)
    run_line(120, 12, 1, 0, 0);        // f1 line 5 active
    run_line(120, 1, 1, 0, 0);         // f1 line 12 blanked
    run_line(120, 2, 1, 0, 0);         // f1 line 1 blanked
    run_line(120, 6, 0, 0, 0);         // f1 line 2 active
    run_line(58, 6, 0, 0, 0);          // R2 strobe on a luma slot
    run_line(120, 7, 0, 0, 0);
    on_pair = 10'd10; off_pair = 10'd10;
    run_line(120, 7, 0, 0, 0);         // R3 start wins, stays blank
    on_pair = 10'd29; off_pair = 10'd2; pat = 2'd1;
    run_line(120, 7, 0, 0, 0);         // R8 saturation at index 7
    run_line(120, 7, 0, 0, 0);
    on_pair = 10'd12; off_pair = 10'd8;
    run_line(120, 7, 0, 0, 0);         // R8 minimum width
    run_line(120, 7, 0, 0, 0);
    while (q.size() > 0) @(negedge clk);
    done = 1;
    finish_run();
  end

endmodule